// File: doc/BRIEF.md
# Double-Buffered Compare/Reload PWM Timer Bank

A bank of independent 16-bit up-counting PWM channels. Each channel counts prescaled ticks. When its counter equals the active compare value, the channel output goes high and the counter jumps to the programmed load value. When the counter passes through its all-ones value, it wraps to zero and the output goes low. The low phase therefore lasts `compare + 1` ticks and the high phase lasts `65536 - load` ticks. For a period of `P` ticks and a duty of `d` ticks, software writes `compare = P - d - 1` and `load = 65536 - d`.

Compare writes go to a holding register. The holding value moves into the active compare register only at a match instant. The load value is sampled from its holding register only at the match. A duty change made while the channel runs therefore never stretches or shortens the period that is in progress. While a channel is stopped, a compare write also updates the active compare, and a load write presets the counter.

A per-channel divide exponent selects the tick rate, a shared run register starts or stops any set of channels in one write, and two override bits pin the output low or high for 0 % and 100 % duty.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset, every channel output is 0, and every readable register (compare holding, load holding, control, counter, run) reads 0.
- R2: On a tick, a counter that is not at its compare value increments by one. From 0xFFFF it wraps to 0, and the channel output becomes 0.
- R3: On a tick where the counter equals the active compare, the counter takes the load holding value and the channel output becomes 1.
- R4: The active compare changes only at a match, where it takes the compare holding value, or through a write while the channel is stopped. A compare or load write made while the channel runs does not alter the period in progress.
- R5: While a channel is stopped, a compare write also sets the active compare, and a load write also sets the counter to the written value.
- R6: Control bits [2:0] hold an exponent n (0 to 7). A running channel ticks once every 2^n clocks.
- R7: Run register bit i starts (1) or stops (0) channel i. One write can start several channels in the same cycle. Stopping holds the counter and prescaler without clearing them.
- R8: Control bit 4 forces the output high, and control bit 3 forces it low. Bit 4 wins when both are set. The counter keeps running while forced, and clearing both bits restores the timer output.
- R9: Address bit 4 = 1 selects the run register. Otherwise bits [3:2] select the channel and bits [1:0] select the register: 0 compare holding, 1 load holding, 2 control, 3 counter (read-only). Read data is combinational from the address.
- R10: With compare = P - d - 1 and load = 65536 - d, for 0 < d < P, the output repeats every P ticks and is high for d ticks of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address (run select, channel, register) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| pwm_o | output | 4 | Channel outputs |

## Verification
A register write is applied at the edge that samples the strobe, so the read data and every counter, compare or run effect of that write are due one clock later. A tick also lands at an edge, and the resulting counter and output change appears right after that same edge. An override bit reaches the output in the cycle after its control write. The bench drives inputs on the falling edge and advances its behavioural model at each rising edge, using only values from before that edge. It then compares outputs and read data on the next falling edge, so every expected value is taken exactly one register stage after its cause. Period and high-time measurements count falling-edge samples between output transitions.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned EXP_W  = 3;
  localparam int unsigned CTRL_W = EXP_W + 2;

  typedef enum logic [1:0] {
    SEL_CMP  = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             force_hi;
    logic             force_lo;
    logic [EXP_W-1:0] div_exp;
  } chan_ctrl_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned EXP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (1 << EXP_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask   = ~({DIV_W{1'b1}} << exp_i);
  assign tick_o = run_i && ((div_q & mask) == mask);

  // free-running divider, frozen while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (run_i) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              wr_cmp_i,
  input  logic              wr_load_i,
  input  logic              wr_ctrl_i,
  output logic [CNT_W-1:0]  cmp_sh_o,
  output logic [CNT_W-1:0]  load_sh_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cmp_act_o,
  output logic              tick_o,
  output logic              level_o,
  output logic              pwm_o
);
  logic [CNT_W-1:0] cnt_q, cmp_act_q, cmp_sh_q, load_sh_q;
  chan_ctrl_t       ctrl_q;
  logic             level_q;
  logic             tick;
  logic             match;
  logic             at_top;

  pwm_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .exp_i  (ctrl_q.div_exp),
    .tick_o (tick)
  );

  assign match  = (cnt_q == cmp_act_q);
  assign at_top = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_sh_q  <= '0;
      load_sh_q <= '0;
      ctrl_q    <= '0;
    end else begin
      if (wr_cmp_i)  cmp_sh_q  <= wdata_i;
      if (wr_load_i) load_sh_q <= wdata_i;
      if (wr_ctrl_i) ctrl_q    <= chan_ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      cmp_act_q <= '0;
      level_q   <= 1'b0;
    end else if (tick) begin
      if (match) begin
        cnt_q     <= load_sh_q;
        cmp_act_q <= cmp_sh_q;
        level_q   <= 1'b1;
      end else if (at_top) begin
        cnt_q   <= '0;
        level_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (!run_i) begin
      // stopped: writes land in the active state directly
      if (wr_cmp_i)  cmp_act_q <= wdata_i;
      if (wr_load_i) cnt_q     <= wdata_i;
    end
  end

  always_comb begin
    if (ctrl_q.force_hi)      pwm_o = 1'b1;
    else if (ctrl_q.force_lo) pwm_o = 1'b0;
    else                      pwm_o = level_q;
  end

  assign cmp_sh_o  = cmp_sh_q;
  assign load_sh_o = load_sh_q;
  assign ctrl_o    = ctrl_q;
  assign cnt_o     = cnt_q;
  assign cmp_act_o = cmp_act_q;
  assign tick_o    = tick;
  assign level_o   = level_q;
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 4,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned IDX_W      = 2,
  parameter int unsigned ADDR_W     = IDX_W + 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [CNT_W-1:0]                 wdata_i,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0] cmp_sh_i,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0] load_sh_i,
  input  logic [NUM_TIMERS-1:0][CTRL_W-1:0] ctrl_i,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_i,
  output logic [NUM_TIMERS-1:0]            wr_cmp_o,
  output logic [NUM_TIMERS-1:0]            wr_load_o,
  output logic [NUM_TIMERS-1:0]            wr_ctrl_o,
  output logic [NUM_TIMERS-1:0]            run_o,
  output logic [CNT_W-1:0]                 rdata_o
);
  logic             glob;
  logic [IDX_W-1:0] idx;
  reg_sel_e         sel;
  logic [NUM_TIMERS-1:0] run_q;

  assign glob = addr_i[ADDR_W-1];
  assign idx  = addr_i[ADDR_W-2:2];
  assign sel  = reg_sel_e'(addr_i[1:0]);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_dec
    logic hit;
    assign hit          = wr_en_i && !glob && (idx == IDX_W'(i));
    assign wr_cmp_o[i]  = hit && (sel == SEL_CMP);
    assign wr_load_o[i] = hit && (sel == SEL_LOAD);
    assign wr_ctrl_o[i] = hit && (sel == SEL_CTRL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                run_q <= '0;
    else if (wr_en_i && glob)   run_q <= wdata_i[NUM_TIMERS-1:0];
  end

  assign run_o = run_q;

  always_comb begin
    rdata_o = '0;
    if (glob) begin
      rdata_o = CNT_W'(run_q);
    end else if (int'(idx) < NUM_TIMERS) begin
      unique case (sel)
        SEL_CMP:  rdata_o = cmp_sh_i[idx];
        SEL_LOAD: rdata_o = load_sh_i[idx];
        SEL_CTRL: rdata_o = CNT_W'(ctrl_i[idx]);
        SEL_CNT:  rdata_o = cnt_i[idx];
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
  import pwm_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 4,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned IDX_W     = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int unsigned ADDR_W    = IDX_W + 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [CNT_W-1:0]      wdata_i,
  output logic [CNT_W-1:0]      rdata_o,
  output logic [NUM_TIMERS-1:0] pwm_o
);
  logic [NUM_TIMERS-1:0]             run_w, tick_w, level_w;
  logic [NUM_TIMERS-1:0]             wr_cmp_w, wr_load_w, wr_ctrl_w;
  logic [NUM_TIMERS-1:0][CNT_W-1:0]  cmp_sh_w, load_sh_w, cnt_w, cmp_act_w;
  logic [NUM_TIMERS-1:0][CTRL_W-1:0] ctrl_w;

  pwm_regs #(
    .NUM_TIMERS (NUM_TIMERS),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W),
    .ADDR_W     (ADDR_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cmp_sh_i  (cmp_sh_w),
    .load_sh_i (load_sh_w),
    .ctrl_i    (ctrl_w),
    .cnt_i     (cnt_w),
    .wr_cmp_o  (wr_cmp_w),
    .wr_load_o (wr_load_w),
    .wr_ctrl_o (wr_ctrl_w),
    .run_o     (run_w),
    .rdata_o   (rdata_o)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chan
    pwm_channel #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_w[i]),
      .wdata_i   (wdata_i),
      .wr_cmp_i  (wr_cmp_w[i]),
      .wr_load_i (wr_load_w[i]),
      .wr_ctrl_i (wr_ctrl_w[i]),
      .cmp_sh_o  (cmp_sh_w[i]),
      .load_sh_o (load_sh_w[i]),
      .ctrl_o    (ctrl_w[i]),
      .cnt_o     (cnt_w[i]),
      .cmp_act_o (cmp_act_w[i]),
      .tick_o    (tick_w[i]),
      .level_o   (level_w[i]),
      .pwm_o     (pwm_o[i])
    );
  end
endmodule

// File: rtl/pwm_reload_timer_chk.sv
module pwm_reload_timer_chk #(
  parameter int unsigned NUM_TIMERS = 4,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned ADDR_W     = 5
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             wr_en_i,
  input logic [ADDR_W-1:0]                addr_i,
  input logic [NUM_TIMERS-1:0]            run_w,
  input logic [NUM_TIMERS-1:0]            tick_w,
  input logic [NUM_TIMERS-1:0]            level_w,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_w,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] cmp_act_w
);
  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_prop
    logic ld_hit;
    assign ld_hit = wr_en_i && !addr_i[ADDR_W-1] &&
                    (addr_i[ADDR_W-2:2] == (ADDR_W-2)'(i)) && (addr_i[1:0] == 2'd1);

    p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_w[i] && (&cnt_w[i]) && (cnt_w[i] != cmp_act_w[i]))
        |=> (cnt_w[i] == '0) && !level_w[i]);

    p_fall_at_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(level_w[i]) |-> (cnt_w[i] == '0));

    p_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_w[i] && (cnt_w[i] == cmp_act_w[i])) |=> level_w[i]);

    p_cmp_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w[i] && !tick_w[i]) |=> $stable(cmp_act_w[i]));

    p_stopped_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_w[i] && !ld_hit) |=> $stable(cnt_w[i]));
  end
endmodule

bind pwm_reload_timer pwm_reload_timer_chk #(
  .NUM_TIMERS (NUM_TIMERS),
  .CNT_W      (CNT_W),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .run_w     (run_w),
  .tick_w    (tick_w),
  .level_w   (level_w),
  .cnt_w     (cnt_w),
  .cmp_act_w (cmp_act_w)
);

// File: tb/pwm_reload_timer_test.sv
module pwm_reload_timer_test;
  localparam int N = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [N-1:0] pwm_o;

  int checks = 0;
  int failures = 0;

  int m_div[N], m_cnt[N], m_cmp[N], m_csh[N], m_lsh[N], m_ctrl[N], m_lvl[N];
  int m_en = 0;

  always #4 clk_i = ~clk_i;

  pwm_reload_timer uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .pwm_o   (pwm_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced with pre-edge inputs
  task automatic model_step();
    bit glob = addr_i[4];
    int idx  = int'(addr_i[3:2]);
    int sel  = int'(addr_i[1:0]);
    int wd   = int'(wdata_i);
    for (int i = 0; i < N; i++) begin
      int en   = (m_en >> i) & 1;
      int mask = (1 << (m_ctrl[i] & 7)) - 1;
      bit tk   = (en == 1) && ((m_div[i] & mask) == mask);
      bit wi   = wr_en_i && !glob && (idx == i);
      int ncnt = m_cnt[i];
      int ncmp = m_cmp[i];
      int nlvl = m_lvl[i];
      if (en == 1) m_div[i] = (m_div[i] + 1) & 127;
      if (tk) begin
        if (m_cnt[i] == m_cmp[i]) begin
          ncnt = m_lsh[i]; ncmp = m_csh[i]; nlvl = 1;
        end else if (m_cnt[i] == 65535) begin
          ncnt = 0; nlvl = 0;
        end else ncnt = m_cnt[i] + 1;
      end else if (en == 0 && wi) begin
        if (sel == 0) ncmp = wd;
        if (sel == 1) ncnt = wd;
      end
      if (wi && sel == 0) m_csh[i] = wd;
      if (wi && sel == 1) m_lsh[i] = wd;
      if (wi && sel == 2) m_ctrl[i] = wd & 31;
      m_cnt[i] = ncnt; m_cmp[i] = ncmp; m_lvl[i] = nlvl;
    end
    if (wr_en_i && glob) m_en = wd & ((1 << N) - 1);
  endtask

  function automatic int model_pwm();
    int v = 0;
    for (int i = 0; i < N; i++) begin
      int b = ((m_ctrl[i] >> 4) & 1) ? 1 : (((m_ctrl[i] >> 3) & 1) ? 0 : m_lvl[i]);
      v |= b << i;
    end
    return v;
  endfunction

  function automatic int model_read();
    int idx = int'(addr_i[3:2]);
    if (addr_i[4]) return m_en;
    case (addr_i[1:0])
      2'd0: return m_csh[idx];
      2'd1: return m_lsh[idx];
      2'd2: return m_ctrl[idx];
      default: return m_cnt[idx];
    endcase
  endfunction

  task automatic cyc();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    chk("R3 pwm_o vs model", int'(pwm_o), model_pwm());
    chk("R9 rdata_o vs model", int'(rdata_o), model_read());
  endtask

  task automatic wr(int a, int d);
    wr_en_i = 1'b1; addr_i = 5'(a); wdata_i = 16'(d);
    cyc();
    wr_en_i = 1'b0;
  endtask

  task automatic measure(int ch, output int per, output int hi);
    int r1 = -1, r2 = -1, f1 = -1;
    bit prev = pwm_o[ch];
    for (int c = 0; c < 400 && r2 < 0; c++) begin
      bit cur;
      cyc();
      cur = pwm_o[ch];
      if (!prev && cur) begin
        if (r1 < 0) r1 = c; else r2 = c;
      end
      if (prev && !cur && r1 >= 0 && f1 < 0) f1 = c;
      prev = cur;
    end
    per = r2 - r1;
    hi  = f1 - r1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int per, hi, v1, allv;
    for (int i = 0; i < N; i++) begin
      m_div[i] = 0; m_cnt[i] = 0; m_cmp[i] = 0; m_csh[i] = 0;
      m_lsh[i] = 0; m_ctrl[i] = 0; m_lvl[i] = 0;
    end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 pwm_o in reset", int'(pwm_o), 0);
    addr_i = 5'd3; #1;
    chk("R1 counter in reset", int'(rdata_o), 0);
    addr_i = 5'd16; #1;
    chk("R1 run reg in reset", int'(rdata_o), 0);
    rst_ni = 1'b1;
    addr_i = 5'd0;
    cyc();

    // channel 0: P=10, d=3 ; channel 1: same, divide by 4
    wr(0, 6); wr(1, 65533);
    addr_i = 5'd3; cyc();
    chk("R5 stopped load presets counter", int'(rdata_o), 65533);
    wr(6, 2); wr(4, 6); wr(5, 65533);
    addr_i = 5'd6; cyc();
    chk("R9 control readback", int'(rdata_o), 2);
    wr(16, 3);
    chk("R7 run reg shows both started", int'(rdata_o), 3);
    measure(0, per, hi);
    chk("R10 period ch0", per, 10);
    chk("R3 high time ch0", hi, 3);
    measure(1, per, hi);
    chk("R6 period ch1 divide by 4", per, 40);
    chk("R6 high time ch1", hi, 12);

    // R4 duty change while running: d=5
    wr(0, 4); wr(1, 65531);
    addr_i = 5'd0; cyc();
    chk("R9 compare holding readback", int'(rdata_o), 4);
    repeat (30) cyc();
    measure(0, per, hi);
    chk("R4 period kept after duty change", per, 10);
    chk("R10 new high time", hi, 5);

    // R8 overrides
    wr(2, 16'h10);
    repeat (3) begin cyc(); chk("R8 force high", int'(pwm_o[0]), 1); end
    wr(2, 16'h18);
    repeat (3) begin cyc(); chk("R8 force high wins", int'(pwm_o[0]), 1); end
    wr(2, 16'h08);
    allv = 0;
    repeat (20) begin cyc(); allv |= int'(pwm_o[0]); end
    chk("R8 force low", allv, 0);
    wr(2, 0);
    repeat (10) cyc();
    measure(0, per, hi);
    chk("R8 timer output resumes period", per, 10);
    chk("R8 timer output resumes high", hi, 5);

    // R7 stop without clearing
    wr(16, 2);
    addr_i = 5'd3; cyc();
    v1 = int'(rdata_o);
    repeat (5) cyc();
    chk("R7 stopped counter held", int'(rdata_o), v1);
    wr(16, 3);
    addr_i = 5'd3; cyc(); cyc();
    chk("R7 restart continues counting", int'(rdata_o != 16'(v1)), 1);

    // R2 wrap on channel 2
    wr(8, 5); wr(9, 16'hFFF0);
    addr_i = 5'd11; cyc();
    chk("R5 preset ch2", int'(rdata_o), 16'hFFF0);
    wr(16, 7);
    addr_i = 5'd11;
    repeat (16) cyc();
    chk("R2 wrap to zero", int'(rdata_o), 0);
    chk("R2 output low after wrap", int'(pwm_o[2]), 0);
    cyc();
    chk("R2 increment after wrap", int'(rdata_o), 1);
    repeat (20) cyc();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule